// File: doc/BRIEF.md
# Packed VLIW Word Expander

This block turns a compacted instruction stream back into full-width very-long instruction words. Storage keeps each instruction as a 32-bit presence word followed only by the slot fields that actually carry an operation. Empty slots take no storage. The expander accepts these 32-bit words one per cycle over a valid/ready handshake. It scatters every packed field into its fixed slot position and puts the no-operation pattern into every slot the presence word leaves out. The finished 1024-bit word is then offered on a valid/ready output.

An instruction occupies between one word (presence word only) and 33 words (all slots in use) of the input stream. The block has a single output register and no skid buffer. While a finished word waits for the consumer, the input is closed. In the cycle the consumer takes the word, the input opens again, so the next presence word can be accepted in that same cycle.

Top module: `vliw_expander`

## Requirements
- R1: The output word is 1024 bits wide and made of 32 slots of 32 bits. Slot i occupies bits [32*i+31 : 32*i]. Bit i of the presence word refers to slot i.
- R2: The first word accepted after reset, and the first word accepted after an instruction is complete, is always read as a presence word. The output never presents a word that was not built from a presence word and its fields.
- R3: The fields that follow a presence word fill the present slots in ascending slot order: the first field goes to the lowest-numbered present slot, the next field to the next present slot, and so on.
- R4: Every slot whose presence bit is 0 holds the no-operation pattern, which is all zeros (32'h0000_0000).
- R5: A presence word of zero completes an instruction on its own. `out_valid` is high in the cycle after that word is accepted, and `out_word` is then all zeros.
- R6: `out_valid` stays low while fields are still outstanding. It rises in the cycle after the last field is accepted.
- R7: While fields are outstanding, and whenever no finished word is held, `in_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, `out_valid` stays high and `out_word` does not change. This holds whatever `in_valid` and `in_data` do.
- R9: When `out_valid` and `out_ready` are both high, `in_ready` is high. A presence word offered in that cycle is accepted and starts the next instruction.
- R10: While `rst_n` is low, and right after it is released, `out_valid` is low, `in_ready` is high, and the block waits for a presence word.
- R11: A presence word of all ones (32'hFFFF_FFFF) is followed by 32 fields. The output then carries all 32 fields in order.
- R12: Cycles in which `in_valid` is low consume no word and do not move the fill position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can accept the input word this cycle |
| in_data | input | 32 | Presence word or packed slot field |
| out_valid | output | 1 | Finished instruction word held |
| out_ready | input | 1 | Consumer takes the finished word |
| out_word | output | 1024 | Expanded instruction word, slot i at bits [32*i+31:32*i] |

## Verification
Every result is due one clock after the input word that completes it is accepted. For a zero presence word that is the presence word itself; otherwise it is the last packed field. `in_ready` follows `out_ready` within the same cycle whenever a finished word is held. The bench drives its inputs on the falling edge and reads the outputs a quarter period later. Each directed latency check therefore looks exactly one sample after the accepting edge, and the scoreboard compares a word only in a sample where both `out_valid` and `out_ready` are high, which is the cycle the transfer takes place.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

  // Phase of the expander
  typedef enum logic [1:0] {
    VLX_WAIT_MASK = 2'd0,
    VLX_GATHER    = 2'd1,
    VLX_PRESENT   = 2'd2
  } vlx_phase_e;

endpackage

// File: rtl/vlx_slot_picker.sv
// Picks the lowest slot still pending and reports the set left after it.
module vlx_slot_picker #(
  parameter int NUM_SLOTS = 32
) (
  input  logic [NUM_SLOTS-1:0] pending,
  output logic [NUM_SLOTS-1:0] pick_oh,
  output logic [NUM_SLOTS-1:0] pending_rest,
  output logic                 pick_last
);

  logic [NUM_SLOTS-1:0] lower_seen;

  // lower_seen[s] is set when any slot below s is pending
  assign lower_seen[0] = 1'b0;

  genvar s;
  generate
    for (s = 1; s < NUM_SLOTS; s++) begin : g_seen
      assign lower_seen[s] = lower_seen[s-1] | pending[s-1];
    end
    for (s = 0; s < NUM_SLOTS; s++) begin : g_pick
      assign pick_oh[s] = pending[s] & ~lower_seen[s];
    end
  endgenerate

  assign pending_rest = pending & ~pick_oh;
  assign pick_last    = (pending_rest == '0);

endmodule

// File: rtl/vlx_word_buffer.sv
// Slot registers of the expanded word: cleared together, written one at a time.
module vlx_word_buffer #(
  parameter int              NUM_SLOTS = 32,
  parameter int              SLOT_W    = 32,
  parameter logic [SLOT_W-1:0] NOP_WORD = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_all,
  input  logic                        wr_en,
  input  logic [NUM_SLOTS-1:0]        wr_oh,
  input  logic [SLOT_W-1:0]           wr_data,
  output logic [NUM_SLOTS*SLOT_W-1:0] word
);

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic              slot_en;
      logic [SLOT_W-1:0] slot_d;
      logic [SLOT_W-1:0] slot_q;

      always_comb begin
        slot_en = clr_all | (wr_en & wr_oh[s]);
        slot_d  = clr_all ? NOP_WORD : wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_q <= NOP_WORD;
        end else if (slot_en) begin
          slot_q <= slot_d;
        end
      end

      assign word[s*SLOT_W +: SLOT_W] = slot_q;
    end
  endgenerate

endmodule

// File: rtl/vlx_ctrl.sv
// Sequencing of presence word, packed fields and output hold.
module vlx_ctrl #(
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NUM_SLOTS-1:0] mask_in,
  input  logic                 out_ready,
  input  logic [NUM_SLOTS-1:0] pending_rest,
  input  logic                 pick_last,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic                 clr_all,
  output logic                 wr_en,
  output logic [NUM_SLOTS-1:0] pending_q
);

  import vlx_pkg::*;

  vlx_phase_e           phase_q, phase_d;
  logic [NUM_SLOTS-1:0] pending_d;
  logic                 pending_en;
  logic                 take;

  assign in_ready  = (phase_q != VLX_PRESENT) | out_ready;
  assign out_valid = (phase_q == VLX_PRESENT);
  assign take      = in_valid & in_ready;

  always_comb begin
    phase_d    = phase_q;
    pending_d  = pending_q;
    pending_en = 1'b0;
    clr_all    = 1'b0;
    wr_en      = 1'b0;
    unique case (phase_q)
      VLX_WAIT_MASK, VLX_PRESENT: begin
        if (take) begin
          clr_all    = 1'b1;
          pending_en = 1'b1;
          pending_d  = mask_in;
          phase_d    = (mask_in == '0) ? VLX_PRESENT : VLX_GATHER;
        end else if (phase_q == VLX_PRESENT && out_ready) begin
          phase_d = VLX_WAIT_MASK;
        end
      end
      VLX_GATHER: begin
        if (take) begin
          wr_en      = 1'b1;
          pending_en = 1'b1;
          pending_d  = pending_rest;
          if (pick_last) begin
            phase_d = VLX_PRESENT;
          end
        end
      end
      default: begin
        phase_d = VLX_WAIT_MASK;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= VLX_WAIT_MASK;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
    end else if (pending_en) begin
      pending_q <= pending_d;
    end
  end

endmodule

// File: rtl/vliw_expander.sv
// Expands a presence word plus packed fields into one full instruction word.
module vliw_expander #(
  parameter int                SLOT_W    = 32,
  parameter int                NUM_SLOTS = 32,
  parameter logic [SLOT_W-1:0] NOP_WORD  = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [SLOT_W-1:0]           in_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [NUM_SLOTS*SLOT_W-1:0] out_word
);

  localparam int WORD_W = NUM_SLOTS * SLOT_W;

  logic [NUM_SLOTS-1:0] pending_q;
  logic [NUM_SLOTS-1:0] pick_oh;
  logic [NUM_SLOTS-1:0] pending_rest;
  logic                 pick_last;
  logic                 clr_all;
  logic                 wr_en;
  logic [WORD_W-1:0]    word_q;

  vlx_slot_picker #(
    .NUM_SLOTS (NUM_SLOTS)
  ) picker_i (
    .pending      (pending_q),
    .pick_oh      (pick_oh),
    .pending_rest (pending_rest),
    .pick_last    (pick_last)
  );

  vlx_ctrl #(
    .NUM_SLOTS (NUM_SLOTS)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .mask_in      (in_data[NUM_SLOTS-1:0]),
    .out_ready    (out_ready),
    .pending_rest (pending_rest),
    .pick_last    (pick_last),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .clr_all      (clr_all),
    .wr_en        (wr_en),
    .pending_q    (pending_q)
  );

  vlx_word_buffer #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .NOP_WORD  (NOP_WORD)
  ) buffer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (clr_all),
    .wr_en   (wr_en),
    .wr_oh   (pick_oh),
    .wr_data (in_data),
    .word    (word_q)
  );

  assign out_word = word_q;

endmodule

// File: rtl/vliw_expander_chk.sv
// Protocol and timing properties of the expander, attached by bind.
module vliw_expander_chk #(
  parameter int                SLOT_W    = 32,
  parameter int                NUM_SLOTS = 32,
  parameter logic [SLOT_W-1:0] NOP_WORD  = '0
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [SLOT_W-1:0]           in_data,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [NUM_SLOTS*SLOT_W-1:0] out_word
);

  localparam int CNT_W = $clog2(NUM_SLOTS + 2);

  logic             take;
  logic [CNT_W-1:0] owed_q;

  assign take = in_valid & in_ready;

  // Fields still owed for the instruction being gathered, counted from the ports
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
    end else if (take) begin
      if (owed_q == '0) begin
        owed_q <= CNT_W'($countones(in_data[NUM_SLOTS-1:0]));
      end else begin
        owed_q <= owed_q - 1'b1;
      end
    end
  end

  AST_STALL_CLOSES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8

  AST_STALL_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R8

  AST_TAKE_OPENS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |-> in_ready); // R9

  AST_GATHER_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q != '0 |-> !out_valid); // R6

  AST_GATHER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q != '0 |-> in_ready); // R7

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R7

  AST_LAST_FIELD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    take && owed_q == CNT_W'(1) |=> out_valid); // R6

  AST_EMPTY_MASK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    take && owed_q == '0 && in_data[NUM_SLOTS-1:0] == '0
    |=> out_valid && out_word == {NUM_SLOTS{NOP_WORD}}); // R5

endmodule

bind vliw_expander vliw_expander_chk #(
  .SLOT_W    (SLOT_W),
  .NUM_SLOTS (NUM_SLOTS),
  .NOP_WORD  (NOP_WORD)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word)
);

// File: tb/vliw_expander_tb_top.sv
module vliw_expander_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int SLOT_W     = 32;
  localparam int NUM_SLOTS  = 32;
  localparam int WORD_W     = SLOT_W * NUM_SLOTS;
  localparam int N_INSTR    = 60;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [SLOT_W-1:0] in_data;
  logic              out_valid;
  logic              out_ready;
  logic [WORD_W-1:0] out_word;

  logic              rand_mode = 1'b0;
  logic              rdy_man   = 1'b0;
  logic              rdy_rand  = 1'b0;

  int checks = 0;
  int errors = 0;
  int popped = 0;
  int pushed = 0;

  logic [WORD_W-1:0] exp_q[$];
  logic [WORD_W-1:0] mon_exp;
  logic [WORD_W-1:0] held;
  logic [WORD_W-1:0] dir_exp;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign out_ready = rand_mode ? rdy_rand : rdy_man;

  vliw_expander dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
  );

  task automatic check(input bit ok, input string req,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compares each word in the sample where the transfer happens
  initial begin
    forever begin
      @(negedge clk);
      if (rand_mode) begin
        rdy_rand = ($urandom_range(0, 3) != 0);
        #(QTR);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 output without instruction", out_word, '0);
          end else begin
            mon_exp = exp_q.pop_front();
            popped++;
            check(out_word == mon_exp, "R1 R3 R4 R11 expanded word", out_word, mon_exp);
          end
        end
      end
    end
  end

  // Driver: offers one word, returns just after the edge that accepts it
  task automatic drive_word(input logic [SLOT_W-1:0] w, input bit gap);
    @(negedge clk);
    if (gap) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_data  = w;
    #(QTR);
    while (!in_ready) begin
      @(negedge clk);
      #(QTR);
    end
    @(posedge clk);
  endtask

  task automatic send_instr(input logic [NUM_SLOTS-1:0] mask);
    logic [WORD_W-1:0] e;
    logic [SLOT_W-1:0] f;
    e = '0;
    drive_word(SLOT_W'(mask), $urandom_range(0, 3) == 0);
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (mask[s]) begin
        f = {1'b1, 31'($urandom)};
        e[s*SLOT_W +: SLOT_W] = f;
        drive_word(f, $urandom_range(0, 4) == 0);
      end
    end
    exp_q.push_back(e);
    pushed++;
  endtask

  task automatic run_all();
    logic [NUM_SLOTS-1:0] m;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    rdy_man  = 1'b0;
    repeat (3) @(negedge clk);
    #(QTR);
    check(out_valid == 1'b0, "R10 out_valid in reset", WORD_W'(out_valid), '0);
    check(in_ready == 1'b1, "R10 in_ready in reset", WORD_W'(in_ready), WORD_W'(1));
    @(negedge clk);
    rst_n = 1'b1;
    #(QTR);
    check(out_valid == 1'b0, "R10 out_valid after reset", WORD_W'(out_valid), '0);

    // R5: zero presence word completes at once
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = '0;
    @(negedge clk);
    in_valid = 1'b0;
    #(QTR);
    check(out_valid == 1'b1, "R5 valid after zero mask", WORD_W'(out_valid), WORD_W'(1));
    check(out_word == '0, "R5 all nop word", out_word, '0);

    // R8: stalled output closes the input and holds the word
    held = out_word;
    in_valid = 1'b1;
    in_data  = 32'h0000_0001;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      in_data = 32'hFFFF_0000 | SLOT_W'(c);
      #(QTR);
      check(in_ready == 1'b0, "R8 input closed in stall", WORD_W'(in_ready), '0);
      check(out_valid && out_word == held, "R8 word held in stall", out_word, held);
    end

    // R9: presence word taken in the same cycle as the output
    @(negedge clk);
    rdy_man  = 1'b1;
    in_data  = 32'h0000_0005;
    #(QTR);
    check(in_ready == 1'b1, "R9 input opens on take", WORD_W'(in_ready), WORD_W'(1));
    @(negedge clk);
    rdy_man = 1'b0;
    in_data = 32'hAAAA_0001;
    #(QTR);
    check(out_valid == 1'b0, "R6 no output while gathering", WORD_W'(out_valid), '0);
    check(in_ready == 1'b1, "R7 ready while gathering", WORD_W'(in_ready), WORD_W'(1));
    @(negedge clk);
    in_data = 32'hBBBB_0002;
    #(QTR);
    check(out_valid == 1'b0, "R6 still gathering", WORD_W'(out_valid), '0);
    @(negedge clk);
    in_valid = 1'b0;
    #(QTR);
    dir_exp = '0;
    dir_exp[0*32 +: 32] = 32'hAAAA_0001;
    dir_exp[2*32 +: 32] = 32'hBBBB_0002;
    check(out_valid == 1'b1, "R6 valid after last field", WORD_W'(out_valid), WORD_W'(1));
    check(out_word == dir_exp, "R1 R3 R4 slots 0 and 2", out_word, dir_exp);

    // take it with no new word offered
    @(negedge clk);
    rdy_man = 1'b1;
    @(negedge clk);
    rdy_man = 1'b0;
    #(QTR);
    check(out_valid == 1'b0, "R9 output released", WORD_W'(out_valid), '0);
    check(in_ready == 1'b1, "R7 ready when empty", WORD_W'(in_ready), WORD_W'(1));

    // R12: bubbles between fields of mask with slots 0 and 31
    in_valid = 1'b1;
    in_data  = 32'h8000_0001;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 32'hDEAD_0000;
    repeat (2) @(negedge clk);
    #(QTR);
    check(out_valid == 1'b0, "R12 bubbles consume nothing", WORD_W'(out_valid), '0);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h1111_1111;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    #(QTR);
    check(out_valid == 1'b0, "R12 bubble keeps slot position", WORD_W'(out_valid), '0);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h2222_2222;
    @(negedge clk);
    in_valid = 1'b0;
    #(QTR);
    dir_exp = '0;
    dir_exp[0*32 +: 32]  = 32'h1111_1111;
    dir_exp[31*32 +: 32] = 32'h2222_2222;
    check(out_word == dir_exp, "R12 R3 slots 0 and 31", out_word, dir_exp);
    exp_q.push_back(dir_exp);
    pushed++;

    // Scoreboard phase with random back-pressure
    @(negedge clk);
    rand_mode = 1'b1;
    for (int n = 0; n < N_INSTR; n++) begin
      case (n % 6)
        0: m = '0;
        1: m = '1;                                     // R11
        2: m = NUM_SLOTS'(1) << (n % NUM_SLOTS);
        3: m = NUM_SLOTS'($urandom) & NUM_SLOTS'($urandom);
        4: m = NUM_SLOTS'($urandom);
        default: m = NUM_SLOTS'($urandom) & NUM_SLOTS'($urandom) & NUM_SLOTS'($urandom);
      endcase
      send_instr(m);
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #(QTR);
    check(popped == pushed, "R2 every instruction delivered once",
          WORD_W'(popped), WORD_W'(pushed));
    check(out_valid == 1'b0, "R2 no extra output", WORD_W'(out_valid), '0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule